// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 128K bytes. The RAM has two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. A user raises a request with a 17-bit address, a byte of write data and a read/write flag. The sequencer accepts it only when it is idle. It then places the address and selects the chip. Next it opens either a write window or a read window, whose length is counted in clock cycles from the clock period and the access grade. It closes the window in a fixed order and signals completion with a one-cycle acknowledge.

The memory data bus is split into an output byte, an input byte and an explicit drive enable, so the pad ring can build the bidirectional pin. Between accesses the controller parks the memory in its low-current standby state: both chip selects are inactive, both strobes are high and the bus is released. An elaboration option makes the address pins drop to zero in standby instead of holding their last value, which cuts toggling on the board.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and after every completed access, the memory side is parked in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. `req_ack` is 0 after reset.
- R2: The address, data and direction are sampled on the clock edge where `req_valid` is seen in the idle state. Changes to the request inputs during a busy access have no effect on that access.
- R3: The address and both chip selects are active for exactly `ADDR_SETUP_CYC` cycles before either strobe goes low.
- R4: The write strobe stays low for exactly WR_CYC = ceil(WE_PULSE_NS*1000/CLK_PERIOD_PS) cycles (7 with the defaults). It is low only while `mem_cs1_n`=0 and `mem_cs2`=1, and the address does not change while it is low.
- R5: The output enable is high in every cycle in which the write strobe is low.
- R6: `mem_dq_oe` rises one cycle after the write strobe falls and drops one cycle after it rises. `mem_dq_out` carries the accepted write byte while it is driven.
- R7: A read holds the output enable low with the write strobe high for exactly RD_CYC cycles. `req_rdata` is loaded from `mem_dq_in` on the edge that raises the output enable again.
- R8: `req_ack` is a one-cycle pulse. It rises ADDR_SETUP_CYC+WR_CYC+1 edges after a write is accepted (9 with the defaults), or ADDR_SETUP_CYC+RD_CYC edges after a read is accepted (10 with the defaults).
- R9: RD_CYC = ceil(ACCESS_NS*1000/CLK_PERIOD_PS) (9 for the 70 ns grade at 8 ns). ACCESS_NS must be 70, 100, 120 or 150.
- R10: The write strobe rises while both chip selects are still active, so the write strobe is the edge that ends each write. The chips are deselected one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Byte returned by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Byte received from the memory |

## Verification
The bench models a memory that returns garbage until the full access time has passed after the output enable falls. A read window one cycle short would therefore capture the wrong byte and miscompare in the scoreboard. The memory model commits a byte only where the write window closes. A write strobe that rose after a chip select, or a drive enable released too early, would store the wrong byte or report an undriven bus. The bench changes the request inputs right after acceptance, so a design that samples them late writes or reads the wrong address. It also measures the setup, pulse and acknowledge latency in cycles, so an off-by-one counter or a stretched acknowledge is caught. Addresses at both ends of the space and a walking-one pattern catch a truncated address bit.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WPULSE,
      ST_WHOLD,
      ST_RWAIT
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

   function automatic bit grade_ok(input int ns);
      return (ns == 70) || (ns == 100) || (ns == 120) || (ns == 150);
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R9: the phase counter never wraps on its own
   a_r9_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && zero) |=> zero);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int CW       = 4,
   parameter int SETUP_C  = 1,
   parameter int WR_C     = 7,
   parameter int RD_C     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              tmr_zero,
   output logic              tmr_load,
   output logic [CW-1:0]     tmr_val,
   output logic              accept,
   output logic              rd_capture,
   output logic              parked,
   output logic [ADDR_W-1:0] addr_q,
   output logic              cs1_n,
   output logic              cs2,
   output logic              we_n,
   output logic              oe_n,
   output logic              ack
);

   localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_C - 1);
   localparam logic [CW-1:0] WR_LD    = CW'(WR_C - 1);
   localparam logic [CW-1:0] RD_LD    = CW'(RD_C - 1);

   seq_state_t state_q;
   logic       is_wr_q;

   always_comb begin
      tmr_load   = 1'b0;
      tmr_val    = '0;
      accept     = 1'b0;
      rd_capture = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               accept   = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = SETUP_LD;
            end
         end
         ST_SETUP: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = is_wr_q ? WR_LD : RD_LD;
            end
         end
         ST_RWAIT: rd_capture = tmr_zero;
         default: ;
      endcase
   end

   assign parked = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         is_wr_q <= 1'b0;
         addr_q  <= '0;
         cs1_n   <= 1'b1;
         cs2     <= 1'b0;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         ack     <= 1'b0;
      end else begin
         ack <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q  <= req_addr;
                  is_wr_q <= req_write;
                  cs1_n   <= 1'b0;
                  cs2     <= 1'b1;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (tmr_zero) begin
                  if (is_wr_q) begin
                     we_n    <= 1'b0;
                     state_q <= ST_WPULSE;
                  end else begin
                     oe_n    <= 1'b0;
                     state_q <= ST_RWAIT;
                  end
               end
            end
            ST_WPULSE: begin
               if (tmr_zero) begin
                  we_n    <= 1'b1;
                  state_q <= ST_WHOLD;
               end
            end
            ST_WHOLD: begin
               cs1_n   <= 1'b1;
               cs2     <= 1'b0;
               ack     <= 1'b1;
               state_q <= ST_IDLE;
            end
            ST_RWAIT: begin
               if (tmr_zero) begin
                  oe_n    <= 1'b1;
                  cs1_n   <= 1'b1;
                  cs2     <= 1'b0;
                  ack     <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R1: standby levels whenever the sequencer rests
   a_r1_idle_park: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (cs1_n && !cs2 && we_n && oe_n));

   // R2: the captured address is frozen for the whole access
   a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(addr_q));

   // R8: acknowledge lasts one cycle
   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R10: write strobe releases before the chip selects
   a_r10_we_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (!cs1_n && cs2));

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              we_n,
   input  logic              rd_capture,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_out  <= '0;
         dq_oe   <= 1'b0;
         rd_data <= '0;
      end else begin
         if (accept)
            dq_out <= wdata_in;
         dq_oe <= ~we_n;
         if (rd_capture)
            rd_data <= dq_in;
      end
   end

   // R6: drive begins one cycle after the strobe falls
   a_r6_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |=> dq_oe);

   // R6: drive ends one cycle after the strobe rises
   a_r6_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |=> !dq_oe);

   // R6: written byte is steady while driven
   a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int CLK_PERIOD_PS  = 8000,
   parameter int ACCESS_NS      = 70,
   parameter int WE_PULSE_NS    = 55,
   parameter int ADDR_SETUP_CYC = 1,
   parameter int ADDR_W         = 17,
   parameter int DATA_W         = 8,
   parameter bit PARK_ADDR_ZERO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic [DATA_W-1:0] req_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs1_n,
   output logic              mem_cs2,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int RD_CYC = ceil_div(ACCESS_NS * 1000, CLK_PERIOD_PS);
   localparam int WR_CYC = ceil_div(WE_PULSE_NS * 1000, CLK_PERIOD_PS);
   localparam int CW     = $clog2(max3(ADDR_SETUP_CYC, WR_CYC, RD_CYC) + 1);

   initial begin
      if (!grade_ok(ACCESS_NS))
         $fatal(1, "access grade %0d ns not supported", ACCESS_NS);
      if (WR_CYC < 2)
         $fatal(1, "write pulse needs at least two cycles");
      if (ADDR_SETUP_CYC < 1)
         $fatal(1, "address setup needs at least one cycle");
      if (CLK_PERIOD_PS <= 0)
         $fatal(1, "clock period must be positive");
   end

   logic              tmr_load;
   logic [CW-1:0]     tmr_val;
   logic              tmr_zero;
   logic              accept;
   logic              rd_capture;
   logic              parked;
   logic [ADDR_W-1:0] addr_q;

   sram_phase_timer #(
      .CW (CW)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sram_seq_fsm #(
      .ADDR_W  (ADDR_W),
      .CW      (CW),
      .SETUP_C (ADDR_SETUP_CYC),
      .WR_C    (WR_CYC),
      .RD_C    (RD_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .tmr_zero   (tmr_zero),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .accept     (accept),
      .rd_capture (rd_capture),
      .parked     (parked),
      .addr_q     (addr_q),
      .cs1_n      (mem_cs1_n),
      .cs2        (mem_cs2),
      .we_n       (mem_we_n),
      .oe_n       (mem_oe_n),
      .ack        (req_ack)
   );

   sram_dq_path #(
      .DATA_W (DATA_W)
   ) u_dq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .wdata_in   (req_wdata),
      .we_n       (mem_we_n),
      .rd_capture (rd_capture),
      .dq_in      (mem_dq_in),
      .dq_out     (mem_dq_out),
      .dq_oe      (mem_dq_oe),
      .rd_data    (req_rdata)
   );

   generate
      if (PARK_ADDR_ZERO) begin : g_addr_zero
         assign mem_addr = parked ? '0 : addr_q;
      end else begin : g_addr_hold
         logic unused_parked;
         assign unused_parked = parked;
         assign mem_addr = addr_q;
      end
   endgenerate

   // R5: output enable stays high through the write strobe
   a_r5_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   // R5: controller and memory never drive the bus together
   a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R4: write strobe only inside a selected window
   a_r4_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs1_n && mem_cs2));

   // R4: address stable while the strobe is low
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   // R7: read strobe never overlaps write strobe
   a_r7_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_cs1_n && mem_cs2));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

   localparam int PER_PS  = 8000;
   localparam int ACC_NS  = 70;
   localparam int WEP_NS  = 55;
   localparam int SET_C   = 1;
   localparam int EXP_R   = (ACC_NS * 1000 + PER_PS - 1) / PER_PS;
   localparam int EXP_W   = (WEP_NS * 1000 + PER_PS - 1) / PER_PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ack;
   logic [7:0]  req_rdata;
   logic [16:0] mem_addr;
   logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_out;
   logic [7:0]  mem_dq_in = 8'hEE;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   byte unsigned dev_mem[int];
   byte unsigned shadow[int];
   byte unsigned exp_q[$];
   byte unsigned cur_wdata;

   always #4 clk = ~clk;

   sram_async_ctrl #(
      .CLK_PERIOD_PS  (PER_PS),
      .ACCESS_NS      (ACC_NS),
      .WE_PULSE_NS    (WEP_NS),
      .ADDR_SETUP_CYC (SET_C)
   ) i_sram_async_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_ack    (req_ack),
      .req_rdata  (req_rdata),
      .mem_addr   (mem_addr),
      .mem_cs1_n  (mem_cs1_n),
      .mem_cs2    (mem_cs2),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_dq_in  (mem_dq_in)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // memory model: commit where the write window closes
   wire wr_win = !mem_we_n && !mem_cs1_n && mem_cs2;
   always @(negedge wr_win) begin
      if (rst_n === 1'b1) begin
         chk(mem_dq_oe === 1'b1, "R6 bus driven at commit", int'(mem_dq_oe), 1);
         chk(!mem_cs1_n && mem_cs2, "R10 strobe ends window", int'(mem_cs1_n), 0);
         chk(mem_dq_out == cur_wdata, "R6 write byte", int'(mem_dq_out), int'(cur_wdata));
         dev_mem[int'(mem_addr)] = mem_dq_out;
      end
   end

   // memory model: data valid only after full access time
   always @(mem_oe_n) begin
      mem_dq_in = 8'hEE;
      if (mem_oe_n === 1'b0) begin
         #(ACC_NS);
         if (!mem_oe_n && !mem_cs1_n && mem_cs2 && dev_mem.exists(int'(mem_addr)))
            mem_dq_in = dev_mem[int'(mem_addr)];
      end
   end

   // monitor and scoreboard
   int sel_cnt = 0;
   int we_cnt = 0;
   int oe_cnt = 0;
   bit strobe_seen = 1'b0;
   bit prev_we_low = 1'b0;
   bit prev_ack = 1'b0;
   bit saw_oe = 1'b0;
   logic [16:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (mem_dq_oe !== prev_we_low)
            chk(1'b0, "R6 drive lag", int'(mem_dq_oe), int'(prev_we_low));
         if (!mem_we_n && !mem_oe_n)
            chk(1'b0, "R5 oe high in write", int'(mem_oe_n), 1);
         if (!mem_we_n && !(!mem_cs1_n && mem_cs2))
            chk(1'b0, "R4 strobe selected", int'(mem_cs1_n), 0);
         if (!mem_we_n && prev_we_low && mem_addr != prev_addr)
            chk(1'b0, "R4 addr stable", int'(mem_addr), int'(prev_addr));

         if (!(!mem_cs1_n && mem_cs2)) begin
            sel_cnt = 0;
            strobe_seen = 1'b0;
         end else if ((!mem_we_n || !mem_oe_n) && !strobe_seen) begin
            chk(sel_cnt == SET_C, "R3 setup cycles", sel_cnt, SET_C);
            strobe_seen = 1'b1;
         end else if (!strobe_seen) begin
            sel_cnt++;
         end

         if (!mem_we_n) we_cnt++;
         else if (we_cnt != 0) begin
            chk(we_cnt == EXP_W, "R4 pulse width", we_cnt, EXP_W);
            we_cnt = 0;
         end
         if (!mem_oe_n) begin
            oe_cnt++;
            saw_oe = 1'b1;
            if (!mem_we_n) chk(1'b0, "R7 we high in read", 0, 1);
         end else if (oe_cnt != 0) begin
            chk(oe_cnt == EXP_R, "R7 R9 read window", oe_cnt, EXP_R);
            oe_cnt = 0;
         end

         if (req_ack) begin
            if (prev_ack) chk(1'b0, "R8 ack single", 1, 0);
            chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
                "R1 park after access", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'hB);
            if (saw_oe) begin
               if (exp_q.size() == 0)
                  chk(1'b0, "R7 unexpected read", int'(req_rdata), 0);
               else begin
                  byte unsigned e;
                  e = exp_q.pop_front();
                  chk(req_rdata == e, "R7 read data", int'(req_rdata), int'(e));
               end
               saw_oe = 1'b0;
            end
         end
         prev_we_low = !mem_we_n;
         prev_ack = req_ack;
         prev_addr = mem_addr;
      end
   end

   task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d);
      int j;
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      if (wr) begin
         cur_wdata = d;
         shadow[int'(a)] = d;
      end else begin
         exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hEE);
      end
      @(posedge clk);
      j = 0;
      @(negedge clk);
      // R2: scramble the request once it has been accepted
      req_addr  = ~a;
      req_wdata = ~d;
      req_write = ~wr;
      while (!req_ack) begin
         j++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(j == (wr ? SET_C + EXP_W + 1 : SET_C + EXP_R), "R8 ack latency", j,
          wr ? SET_C + EXP_W + 1 : SET_C + EXP_R);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs1_n == 1'b1, "R1 reset cs1_n", int'(mem_cs1_n), 1);
      chk(mem_cs2 == 1'b0, "R1 reset cs2", int'(mem_cs2), 0);
      chk(mem_we_n == 1'b1, "R1 reset we_n", int'(mem_we_n), 1);
      chk(mem_oe_n == 1'b1, "R1 reset oe_n", int'(mem_oe_n), 1);
      chk(mem_dq_oe == 1'b0, "R1 reset dq_oe", int'(mem_dq_oe), 0);
      chk(req_ack == 1'b0, "R1 reset ack", int'(req_ack), 0);

      // address extremes and alternating data
      access(1'b1, 17'h00000, 8'h00);
      access(1'b1, 17'h1FFFF, 8'hFF);
      access(1'b1, 17'h0AAAA, 8'h55);
      access(1'b1, 17'h15555, 8'hAA);
      access(1'b0, 17'h1FFFF, 8'h00);
      access(1'b0, 17'h00000, 8'h00);
      access(1'b0, 17'h15555, 8'h00);
      access(1'b0, 17'h0AAAA, 8'h00);

      // walking one on the address bus
      for (int i = 0; i < 17; i++)
         access(1'b1, 17'(1) << i, 8'(8'h11 * (i % 16) + i));
      for (int i = 16; i >= 0; i--)
         access(1'b0, 17'(1) << i, 8'h00);

      // overwrite then read back
      access(1'b1, 17'h01234, 8'h3C);
      access(1'b1, 17'h01234, 8'hC3);
      access(1'b0, 17'h01234, 8'h00);
      access(1'b0, 17'h01234, 8'h00);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      chk(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe,
          "R1 final standby", {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'hB);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

endmodule